// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is a single DMA channel that works through a chain of descriptors held in system memory. Setup logic places a descriptor address on `nextDescIn` and pulses `fetchReq`. The channel then reads a four-word descriptor from that address. The descriptor gives a byte count, a source address, a destination address and a link to the next descriptor. The channel moves the data in bursts over a simple word-wide memory master port. Each burst reads up to `BURST_WORDS` words into a local staging buffer and then writes them out.

When a descriptor's count is used up, the channel pulses `complete`. If `chainMode` is set, it loads the link and fetches the next descriptor. A list whose last link points back to its head forms a ring, and the channel cycles through it until it is aborted. This suits periodic streaming, with one completion pulse per period.

The `srcHold` and `dstHold` settings fix the source or destination address, which suits peripheral data registers. `enable` pauses the channel between bursts. `abort` stops it cleanly at the next burst boundary.

Top module: `dmaChainEngine`

## Requirements
- R1: A fetch loads the descriptor from four consecutive words at pointer +0, +4, +8 and +12. These hold, in order: byte count (bits 16:0), source address, destination address and next-descriptor pointer. The low 4 bits of the pointer are ignored, and the low 2 bits of the two data addresses are ignored.
- R2: From the cycle after a fetch starts, `curDesc` shows the 16-byte-aligned address of the descriptor being processed.
- R3: A descriptor's byte count is a multiple of 4 and at most 65536. It is moved as bursts of `BURST_WORDS` words. All reads of a burst happen before its writes. The last burst is shortened to the words that remain.
- R4: With `srcHold`=1 every read uses the descriptor's source address. With `dstHold`=1 every write uses its destination address. An address that is not held advances by 4 per word.
- R5: `complete` pulses for one cycle at the end of each descriptor, including a descriptor with a count of zero.
- R6: With `chainMode`=1 the channel follows the link after each completion, so a ring is processed indefinitely. With `chainMode`=0 it goes idle after the completion.
- R7: `abort` takes effect only at a burst or fetch-word boundary. The channel then returns to idle without a completion pulse.
- R8: No new fetch word or burst is started while `enable` is low. A burst that has already started runs to its last write.
- R9: After reset and while idle, `busy`, `memReq` and `complete` are low.
- R10: Every memory request carries a word-aligned address. An access completes in the cycle in which `memAck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Permits new fetch words and bursts |
| abort | input | 1 | Stop at the next boundary |
| fetchReq | input | 1 | Start a fetch from `nextDescIn` (honoured while idle) |
| chainMode | input | 1 | Follow descriptor links |
| srcHold | input | 1 | Keep the source address fixed |
| dstHold | input | 1 | Keep the destination address fixed |
| nextDescIn | input | ADDR_W | Head descriptor pointer |
| memReq | output | 1 | Memory access request |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | DATA_W | Write data |
| memAck | input | 1 | Access accepted this cycle |
| memRdata | input | DATA_W | Read data, valid with `memAck` |
| busy | output | 1 | Channel not idle |
| complete | output | 1 | End-of-descriptor pulse |
| curDesc | output | ADDR_W | Address of the current descriptor |

## Verification
The bench builds the channel with the default `BURST_WORDS`=4 and 32-bit address and data. A 16-byte count then fills exactly one burst, and a 24-byte count needs a full burst plus a two-word remainder, which exercises the shortened final burst. Because a 64-byte descriptor spans four bursts, pauses and aborts can land in the middle of a transfer, and the bench can check that exactly one burst's worth of writes went through. A two-entry ring with 8-byte periods makes the link and wrap-around paths repeat many times within a short run.

// File: rtl/dmaChainPkg.sv
package dmaChainPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_READ,
    ST_WRITE
  } chStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPtr;     // load curDesc, clear word index
    logic usePtrIn;    // pointer comes from the port, not the link
    logic takeWord;    // capture one descriptor word
    logic startBurst;  // size the next burst
    logic readBeat;    // one burst word read
    logic writeBeat;   // one burst word written
    logic selFetch;    // address from descriptor pointer
    logic selDst;      // address from destination register
  } dpCtlT;

endpackage

// File: rtl/dmaChainDatapath.sv
module dmaChainDatapath
  import dmaChainPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BURST_WORDS = 4,
  parameter int CNT_W       = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtlT             ctl,
  input  logic              srcHold,
  input  logic              dstHold,
  input  logic [ADDR_W-1:0] nextDescIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] curDesc,
  output logic              beatLast,
  output logic              fetchLast,
  output logic              remainZero
);

  localparam int IDX_W = ($clog2(BURST_WORDS) < 2) ? 2 : $clog2(BURST_WORDS);
  localparam int BUF_D = 1 << IDX_W;
  localparam int LEN_W = IDX_W + 1;
  localparam int RW_W  = CNT_W - 2;

  logic [ADDR_W-1:0] curQ, linkQ, srcQ, dstQ;
  logic [CNT_W-1:0]  remainQ;
  logic [IDX_W-1:0]  idxQ;
  logic [LEN_W-1:0]  lenQ;
  logic [DATA_W-1:0] bufWord [BUF_D];

  logic [RW_W-1:0]   remainWords;
  logic [LEN_W-1:0]  lenNext;
  logic [ADDR_W-1:0] rdAddr;

  assign remainWords = remainQ[CNT_W-1:2];
  assign lenNext = (remainWords >= RW_W'(BURST_WORDS)) ? LEN_W'(BURST_WORDS)
                                                       : LEN_W'(remainWords);
  assign rdAddr = ADDR_W'(memRdata);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ    <= '0;
      linkQ   <= '0;
      srcQ    <= '0;
      dstQ    <= '0;
      remainQ <= '0;
      idxQ    <= '0;
      lenQ    <= '0;
    end else begin
      if (ctl.loadPtr) begin
        curQ <= ctl.usePtrIn ? {nextDescIn[ADDR_W-1:4], 4'b0000}
                             : {linkQ[ADDR_W-1:4], 4'b0000};
        idxQ <= '0;
      end
      if (ctl.takeWord) begin
        case (idxQ)
          IDX_W'(0): remainQ <= {memRdata[CNT_W-1:2], 2'b00};
          IDX_W'(1): srcQ    <= {rdAddr[ADDR_W-1:2], 2'b00};
          IDX_W'(2): dstQ    <= {rdAddr[ADDR_W-1:2], 2'b00};
          default:   linkQ   <= rdAddr;
        endcase
        idxQ <= idxQ + IDX_W'(1);
      end
      if (ctl.startBurst) begin
        lenQ <= lenNext;
        idxQ <= '0;
      end
      if (ctl.readBeat) begin
        if (!srcHold) srcQ <= srcQ + ADDR_W'(4);
        idxQ <= beatLast ? '0 : idxQ + IDX_W'(1);
      end
      if (ctl.writeBeat) begin
        if (!dstHold) dstQ <= dstQ + ADDR_W'(4);
        remainQ <= remainQ - CNT_W'(4);
        idxQ    <= beatLast ? '0 : idxQ + IDX_W'(1);
      end
    end
  end

  // staging buffer, one register per word
  for (genvar g = 0; g < BUF_D; g++) begin : gBuf
    logic [DATA_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   wordQ <= '0;
      else if (ctl.readBeat && idxQ == IDX_W'(g))  wordQ <= memRdata;
    end
    assign bufWord[g] = wordQ;
  end

  assign beatLast   = ({1'b0, idxQ} == lenQ - LEN_W'(1));
  assign fetchLast  = (idxQ == IDX_W'(3));
  assign remainZero = (remainQ == '0);
  assign curDesc    = curQ;
  assign memWdata   = bufWord[idxQ];
  assign memAddr    = ctl.selFetch ? curQ + ADDR_W'({idxQ, 2'b00})
                    : ctl.selDst   ? dstQ : srcQ;

endmodule

// File: rtl/dmaChainControl.sv
module dmaChainControl
  import dmaChainPkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  enable,
  input  logic  abort,
  input  logic  fetchReq,
  input  logic  chainMode,
  input  logic  memAck,
  input  logic  beatLast,
  input  logic  fetchLast,
  input  logic  remainZero,
  output dpCtlT ctl,
  output logic  memReq,
  output logic  memWrite,
  output logic  busy,
  output logic  complete
);

  chStateT stateQ, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    ctl      = '0;
    memReq   = 1'b0;
    memWrite = 1'b0;
    complete = 1'b0;
    stateNxt = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (fetchReq) begin
          ctl.loadPtr  = 1'b1;
          ctl.usePtrIn = 1'b1;
          stateNxt     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        ctl.selFetch = 1'b1;
        if (abort) begin
          stateNxt = ST_IDLE;
        end else if (enable) begin
          memReq = 1'b1;
          if (memAck) begin
            ctl.takeWord = 1'b1;
            if (fetchLast) stateNxt = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (abort) begin
          stateNxt = ST_IDLE;
        end else if (remainZero) begin
          complete = 1'b1;
          if (chainMode) begin
            ctl.loadPtr = 1'b1;
            stateNxt    = ST_FETCH;
          end else begin
            stateNxt = ST_IDLE;
          end
        end else if (enable) begin
          ctl.startBurst = 1'b1;
          stateNxt       = ST_READ;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.readBeat = 1'b1;
          if (beatLast) stateNxt = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq     = 1'b1;
        memWrite   = 1'b1;
        ctl.selDst = 1'b1;
        if (memAck) begin
          ctl.writeBeat = 1'b1;
          if (beatLast) stateNxt = ST_CHECK;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/dmaChainEngine.sv
module dmaChainEngine
  import dmaChainPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BURST_WORDS = 4,
  parameter int CNT_W       = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              abort,
  input  logic              fetchReq,
  input  logic              chainMode,
  input  logic              srcHold,
  input  logic              dstHold,
  input  logic [ADDR_W-1:0] nextDescIn,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              complete,
  output logic [ADDR_W-1:0] curDesc
);

  dpCtlT ctl;
  logic  beatLast, fetchLast, remainZero;

  dmaChainControl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .abort(abort),
    .fetchReq(fetchReq), .chainMode(chainMode), .memAck(memAck),
    .beatLast(beatLast), .fetchLast(fetchLast), .remainZero(remainZero),
    .ctl(ctl), .memReq(memReq), .memWrite(memWrite),
    .busy(busy), .complete(complete)
  );

  dmaChainDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BURST_WORDS(BURST_WORDS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .srcHold(srcHold), .dstHold(dstHold), .nextDescIn(nextDescIn),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .curDesc(curDesc), .beatLast(beatLast), .fetchLast(fetchLast),
    .remainZero(remainZero)
  );

endmodule

// File: rtl/dmaChainChecker.sv
module dmaChainChecker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              abort,
  input logic [ADDR_W-1:0] nextDescIn,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              complete,
  input logic [ADDR_W-1:0] curDesc
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq); // R9

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    complete |-> busy); // R5

  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    abort |-> !complete); // R7

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00); // R10

  AST_FETCH_POINTER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> curDesc == {$past(nextDescIn[ADDR_W-1:4]), 4'b0000}); // R2

endmodule

bind dmaChainEngine dmaChainChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .abort(abort), .nextDescIn(nextDescIn),
  .memReq(memReq), .memAddr(memAddr), .busy(busy),
  .complete(complete), .curDesc(curDesc)
);

// File: tb/dmaChainEngine_tb.sv
`timescale 1ns/1ps
module dmaChainEngine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0, abort = 1'b0, fetchReq = 1'b0;
  logic        chainMode = 1'b0, srcHold = 1'b0, dstHold = 1'b0;
  logic [31:0] nextDescIn = '0;
  logic        memReq, memWrite, memAck, busy, complete;
  logic [31:0] memAddr, memWdata, memRdata, curDesc;

  logic [31:0] mem [0:255];
  int nChk = 0, nBad = 0;
  int wrCount = 0, rdCount = 0, doneCount = 0, misAlign = 0;

  always #2 clk = ~clk;

  dmaChainEngine u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .abort(abort),
    .fetchReq(fetchReq), .chainMode(chainMode), .srcHold(srcHold),
    .dstHold(dstHold), .nextDescIn(nextDescIn), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .busy(busy),
    .complete(complete), .curDesc(curDesc)
  );

  // zero-wait memory model
  assign memAck   = memReq;
  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (memReq && memWrite) begin
      mem[memAddr[9:2]] <= memWdata;
      wrCount <= wrCount + 1;
    end
    if (memReq && !memWrite) rdCount <= rdCount + 1;
    if (memReq && memAddr[1:0] != 2'b00) misAlign <= misAlign + 1;
    if (complete) doneCount <= doneCount + 1;
  end

  typedef struct packed {
    logic [15:0] bytes;
    logic        sh;
    logic        dh;
  } vecT;

  localparam vecT VECS [0:4] = '{
    '{16'd16, 1'b0, 1'b0},
    '{16'd24, 1'b0, 1'b0},
    '{16'd8,  1'b1, 1'b0},
    '{16'd12, 1'b0, 1'b1},
    '{16'd0,  1'b0, 1'b0}
  };

  function automatic logic [31:0] srcVal(input int k);
    return 32'hC0DE_0000 + 32'(k);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic putDesc(input int base, input logic [31:0] cnt, input logic [31:0] s,
                         input logic [31:0] d, input logic [31:0] nx);
    mem[base] = cnt; mem[base+1] = s; mem[base+2] = d; mem[base+3] = nx;
  endtask

  task automatic clearDst();
    for (int k = 128; k < 160; k++) mem[k] = '0;
  endtask

  task automatic startAt(input logic [31:0] ptr);
    @(negedge clk);
    nextDescIn = ptr;
    fetchReq   = 1'b1;
    @(negedge clk);
    fetchReq   = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    for (int k = 0; k < 16; k++) mem[64+k] = srcVal(k);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy after reset", {31'b0, busy}, 32'd0);
    check("R9 memReq after reset", {31'b0, memReq}, 32'd0);
    check("R9 complete after reset", {31'b0, complete}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    enable = 1'b1;

    // vector table: single descriptors, chain off
    for (int v = 0; v < 5; v++) begin
      automatic int n = int'(VECS[v].bytes) / 4;
      automatic int w0 = wrCount;
      automatic int d0 = doneCount;
      clearDst();
      putDesc(0, 32'(VECS[v].bytes), 32'h100, 32'h200, 32'h0);
      srcHold = VECS[v].sh;
      dstHold = VECS[v].dh;
      chainMode = 1'b0;
      startAt(32'h0);
      waitIdle();
      repeat (2) @(negedge clk);
      check("R3 write count", 32'(wrCount - w0), 32'(n));
      check("R5 one completion", 32'(doneCount - d0), 32'd1);
      check("R6 idle without chain", {31'b0, busy}, 32'd0);
      if (VECS[v].dh) begin
        check("R4 dst held value", mem[128], n > 0 ? srcVal(VECS[v].sh ? 0 : n-1) : 32'd0);
        check("R4 dst held, next word untouched", mem[129], 32'd0);
      end else begin
        for (int k = 0; k < n; k++)
          check(VECS[v].sh ? "R4 src held copy" : "R3 copy word",
                mem[128+k], srcVal(VECS[v].sh ? 0 : k));
        check("R3 no overrun", mem[128+n], 32'd0);
      end
    end
    srcHold = 1'b0;
    dstHold = 1'b0;

    // R1/R2/R8: misaligned pointer, start while disabled
    begin
      automatic int r0 = rdCount;
      clearDst();
      putDesc(4, 32'd4, 32'h108, 32'h200, 32'h0);
      enable = 1'b0;
      startAt(32'h17);
      check("R2 curDesc aligned pointer", curDesc, 32'h10);
      repeat (10) @(negedge clk);
      check("R8 no request while disabled", 32'(rdCount - r0), 32'd0);
      check("R8 still busy", {31'b0, busy}, 32'd1);
      enable = 1'b1;
      waitIdle();
      @(negedge clk);
      check("R1 descriptor words used", mem[128], srcVal(2));
    end

    // R8: pause during a burst lets the burst finish
    begin
      automatic int w0 = wrCount;
      automatic int r0 = rdCount;
      automatic int d0 = doneCount;
      clearDst();
      putDesc(0, 32'd64, 32'h100, 32'h200, 32'h0);
      startAt(32'h0);
      for (int i = 0; i < 100 && (rdCount - r0) < 5; i++) @(negedge clk);
      enable = 1'b0;
      repeat (30) @(negedge clk);
      check("R8 in-flight burst completes", 32'(wrCount - w0), 32'd4);
      check("R8 paused busy", {31'b0, busy}, 32'd1);
      enable = 1'b1;
      waitIdle();
      @(negedge clk);
      check("R8 resumed total writes", 32'(wrCount - w0), 32'd16);
      check("R3 last word after resume", mem[143], srcVal(15));
      check("R5 completion after resume", 32'(doneCount - d0), 32'd1);
    end

    // R7: abort mid-transfer
    begin
      automatic int w0 = wrCount;
      automatic int d0 = doneCount;
      automatic int r1;
      putDesc(0, 32'd64, 32'h100, 32'h200, 32'h0);
      startAt(32'h0);
      for (int i = 0; i < 100 && wrCount == w0; i++) @(negedge clk);
      abort = 1'b1;
      waitIdle();
      abort = 1'b0;
      r1 = rdCount;
      repeat (10) @(negedge clk);
      check("R7 stop at burst boundary", 32'(wrCount - w0), 32'd4);
      check("R7 no completion", 32'(doneCount - d0), 32'd0);
      check("R7 idle after abort", {31'b0, busy}, 32'd0);
      check("R7 no requests after abort", 32'(rdCount - r1), 32'd0);
    end

    // R6: two-entry ring loops
    begin
      automatic int d0 = doneCount;
      clearDst();
      putDesc(0, 32'd8, 32'h100, 32'h200, 32'h10);
      putDesc(4, 32'd8, 32'h108, 32'h208, 32'h00);
      chainMode = 1'b1;
      startAt(32'h0);
      for (int i = 0; i < 2000 && (doneCount - d0) < 6; i++) @(negedge clk);
      check("R6 ring keeps completing", 32'((doneCount - d0) >= 6), 32'd1);
      check("R6 ring still busy", {31'b0, busy}, 32'd1);
      for (int k = 0; k < 4; k++) check("R6 ring data", mem[128+k], srcVal(k));
      abort = 1'b1;
      waitIdle();
      abort = 1'b0;
      chainMode = 1'b0;
      @(negedge clk);
      check("R7 ring stopped", {31'b0, busy}, 32'd0);
    end

    check("R10 aligned requests", 32'(misAlign), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule